// File: doc/BRIEF.md
# Streaming Histogram Accumulator

This block counts how often each bin value occurs in a stream of samples. A sample is counted only when its valid qualifier is high. The bin index is the top field of the data word, and the low data bits are discarded. There is one counter per bin, held in a synchronous memory. Each counter is updated through a read-modify-write pipeline. The result of every update appears on a debug port four cycles after the sample was presented.

An interval marker that arrives with a valid sample starts a new counting interval. From that point every bin counts as empty, and the marked sample itself counts as one. A second read port lets the caller fetch the count of any bin for the current interval, with a fixed one-cycle latency. This port never holds up the stream.

A memory read returns its data some cycles after the request. So a bin that repeats within three samples would see a stale value in memory. The block compares each sample with the three samples ahead of it and takes the newest matching count still in flight. A small epoch tag on each sample stops counts from before an interval marker from being forwarded across it. A per-bin flag marks which bins have been written in the current interval. Bins without the flag read as zero, so starting an interval needs no sweep of the memory.

Top module: `hist_accum`

## Requirements
- R1: The bin index is `in_data[DATA_W-1 -: BIN_W]` (bits 4:2 at the defaults). The remaining low data bits have no effect on any count.
- R2: A cycle with `in_valid` low changes no count, and four cycles later `dbg_valid` is low.
- R3: A valid sample presented in cycle n makes `dbg_valid` high in cycle n+4. In that cycle `dbg_bin` holds its bin and `dbg_count` holds the bin's count for the interval, including that sample.
- R4: Valid samples to the same bin on consecutive cycles each raise that bin's count by exactly one.
- R5: Alternating bins on successive valid cycles (0,1,0,1) give exact counts. This covers a repeat at distance two.
- R6: A repeat at distance three, such as 0,1,1,0, gives exact counts.
- R7: A cycle with both `in_sync` and `in_valid` high restarts the interval. That sample's bin reports 1, and every other bin counts from zero. This holds even when the same bin was still in flight from before the marker, and for markers on back-to-back cycles.
- R8: When `mm_rd_en` is high in cycle n, `mm_rvalid` is high in cycle n+1. In that cycle `mm_rdata` holds the current-interval count of bin `mm_addr`, which is 0 for a bin not hit since the last marker. `mm_rvalid` is low in the cycle after a cycle with `mm_rd_en` low.
- R9: Reads on the memory-mapped port during streaming never alter or delay the stream's updates.
- R10: A bin reaches a count of MAX_SAMPLES (200 by default) within one interval without wrapping.
- R11: After reset `dbg_valid` and `mm_rvalid` are low, and every bin reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample qualifier |
| in_sync | input | 1 | Interval restart marker, meaningful only with `in_valid` |
| in_data | input | DATA_W | Sample word; the top BIN_W bits select the bin |
| mm_rd_en | input | 1 | Read request on the memory-mapped port |
| mm_addr | input | BIN_W | Bin to read |
| mm_rvalid | output | 1 | Read data valid, one cycle after the request |
| mm_rdata | output | CNT_W | Current-interval count of the requested bin |
| dbg_valid | output | 1 | A counter update is being written |
| dbg_bin | output | BIN_W | Bin being written |
| dbg_count | output | CNT_W | New count being written |

## Verification
A wrong forwarding choice, a stale memory value or a missed interval restart shows up on `dbg_count` exactly four cycles after the offending sample. From then on the error persists in that bin, so the very next hit on the same bin also reports a wrong value. The bench replays patterns with repeats at distances one to four, with and without idle gaps, across interval markers, and with concurrent port reads. It compares every cycle of the debug port against an arithmetic histogram. After each phase it reads all bins back over the memory-mapped port, which exposes stale flags or lost writes that the debug stream alone would hide.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // Epoch tag carried by each sample; wide enough that up to four restarts
  // between a sample's capture and its write never alias.
  localparam int EPOCH_W = 3;
  typedef logic [EPOCH_W-1:0] epoch_t;
endpackage

// File: rtl/hist_store.sv
module hist_store #(
  parameter int BIN_W = 3,
  parameter int CNT_W = 8,
  localparam int NBINS = 1 << BIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_base,
  input  logic             wr_en,
  input  logic [BIN_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wr_mark,
  input  logic             mm_en,
  input  logic [BIN_W-1:0] mm_addr,
  output logic             mm_valid,
  output logic [CNT_W-1:0] mm_data
);
  logic [CNT_W-1:0] mem [NBINS];
  logic [NBINS-1:0] live_q, live_d;
  logic [CNT_W-1:0] rd_d, mm_d;

  // counter storage: no reset, guarded by the live flags
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    live_d = live_q;
    if (clr)
      live_d = '0;
    else if (wr_en && wr_mark)
      live_d[wr_addr] = 1'b1;
  end

  always_comb begin
    rd_d = live_q[rd_addr] ? mem[rd_addr] : '0;
    mm_d = live_q[mm_addr] ? mem[mm_addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      rd_base  <= '0;
      mm_valid <= 1'b0;
      mm_data  <= '0;
    end else begin
      live_q   <= live_d;
      rd_base  <= rd_d;
      mm_valid <= mm_en;
      if (mm_en) mm_data <= mm_d;
    end
  end
endmodule

// File: rtl/hist_fwd.sv
module hist_fwd
  import hist_pkg::*;
#(
  parameter int BIN_W = 3,
  parameter int CNT_W = 8,
  parameter int NSRC  = 3
) (
  input  logic             x_vld,
  input  logic [BIN_W-1:0] x_bin,
  input  epoch_t           x_ep,
  input  logic [CNT_W-1:0] ram_base,
  input  logic             src_we  [NSRC],
  input  epoch_t           src_ep  [NSRC],
  input  logic [BIN_W-1:0] src_bin [NSRC],
  input  logic [CNT_W-1:0] src_cnt [NSRC],
  output logic [CNT_W-1:0] upd_cnt
);
  logic [CNT_W-1:0] base;

  // index 0 is the newest in-flight update; scan oldest first so newest wins
  always_comb begin
    base = ram_base;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src_we[i] && (src_ep[i] == x_ep) && (src_bin[i] == x_bin))
        base = src_cnt[i];
    end
    upd_cnt = x_vld ? base + CNT_W'(1) : base;
  end
endmodule

// File: rtl/hist_accum.sv
module hist_accum
  import hist_pkg::*;
#(
  parameter int DATA_W = 5,
  parameter int BIN_W = 3,
  parameter int MAX_SAMPLES = 200,
  localparam int CNT_W = $clog2(MAX_SAMPLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic [DATA_W-1:0] in_data,
  input  logic              mm_rd_en,
  input  logic [BIN_W-1:0]  mm_addr,
  output logic              mm_rvalid,
  output logic [CNT_W-1:0]  mm_rdata,
  output logic              dbg_valid,
  output logic [BIN_W-1:0]  dbg_bin,
  output logic [CNT_W-1:0]  dbg_count
);
  localparam int NSRC  = 3;
  localparam int LOW_W = DATA_W - BIN_W;

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  generate
    if (LOW_W > 0) begin : g_low
      logic unused_low_bits;
      assign unused_low_bits = ^in_data[LOW_W-1:0];
    end
  endgenerate

  logic             sync_in;
  epoch_t           ep_q, ep_d;
  logic [BIN_W-1:0] in_bin;
  assign sync_in = in_valid & in_sync;
  assign ep_d    = ep_q + epoch_t'(sync_in);
  assign in_bin  = in_data[DATA_W-1 -: BIN_W];

  // pipeline: s1 issues the read, s2 has memory data, s3 computes
  logic             s1_vld, s2_vld, s3_vld;
  logic [BIN_W-1:0] s1_bin, s2_bin, s3_bin;
  epoch_t           s1_ep, s2_ep, s3_ep;
  logic [CNT_W-1:0] rd_base, s3_base, upd_cnt;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ep_q   <= '0;
      s1_vld <= 1'b0; s1_bin <= '0; s1_ep <= '0;
      s2_vld <= 1'b0; s2_bin <= '0; s2_ep <= '0;
      s3_vld <= 1'b0; s3_bin <= '0; s3_ep <= '0; s3_base <= '0;
    end else begin
      ep_q   <= ep_d;
      s1_vld <= in_valid;
      s2_vld <= s1_vld;
      s3_vld <= s2_vld;
      if (in_valid) begin
        s1_bin <= in_bin;
        s1_ep  <= ep_d;
      end
      if (s1_vld) begin
        s2_bin <= s1_bin;
        s2_ep  <= s1_ep;
      end
      if (s2_vld) begin
        s3_bin  <= s2_bin;
        s3_ep   <= s2_ep;
        s3_base <= rd_base;
      end
    end
  end

  // in-flight updates: index 0 feeds the memory write port
  logic             h_we  [NSRC];
  epoch_t           h_ep  [NSRC];
  logic [BIN_W-1:0] h_bin [NSRC];
  logic [CNT_W-1:0] h_cnt [NSRC];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      h_we[0] <= 1'b0; h_ep[0] <= '0; h_bin[0] <= '0; h_cnt[0] <= '0;
    end else begin
      h_we[0] <= s3_vld;
      if (s3_vld) begin
        h_ep[0]  <= s3_ep;
        h_bin[0] <= s3_bin;
        h_cnt[0] <= upd_cnt;
      end
    end
  end

  generate
    for (genvar g = 1; g < NSRC; g++) begin : g_hist
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) begin
          h_we[g] <= 1'b0; h_ep[g] <= '0; h_bin[g] <= '0; h_cnt[g] <= '0;
        end else begin
          h_we[g] <= h_we[g-1];
          if (h_we[g-1]) begin
            h_ep[g]  <= h_ep[g-1];
            h_bin[g] <= h_bin[g-1];
            h_cnt[g] <= h_cnt[g-1];
          end
        end
      end
    end
  endgenerate

  hist_fwd #(.BIN_W(BIN_W), .CNT_W(CNT_W), .NSRC(NSRC)) u_fwd (
    .x_vld   (s3_vld),
    .x_bin   (s3_bin),
    .x_ep    (s3_ep),
    .ram_base(s3_base),
    .src_we  (h_we),
    .src_ep  (h_ep),
    .src_bin (h_bin),
    .src_cnt (h_cnt),
    .upd_cnt (upd_cnt)
  );

  hist_store #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clr     (sync_in),
    .rd_addr (s1_bin),
    .rd_base (rd_base),
    .wr_en   (h_we[0]),
    .wr_addr (h_bin[0]),
    .wr_data (h_cnt[0]),
    .wr_mark (h_ep[0] == ep_q),
    .mm_en   (mm_rd_en),
    .mm_addr (mm_addr),
    .mm_valid(mm_rvalid),
    .mm_data (mm_rdata)
  );

  assign dbg_valid = h_we[0];
  assign dbg_bin   = h_bin[0];
  assign dbg_count = h_cnt[0];

  // cycles since reset release, saturating; keeps $past inside that window
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)             age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end

  a_r3_update_needs_sample: assert property (@(posedge clk) disable iff (!rst_ns)
    dbg_valid |-> $past(in_valid, 4));

  a_r2_sample_reaches_port: assert property (@(posedge clk) disable iff (!rst_ns)
    (age_q >= 3'd5) && $past(in_valid, 4) |-> dbg_valid);

  a_r7_restart_counts_one: assert property (@(posedge clk) disable iff (!rst_ns)
    (age_q >= 3'd5) && $past(in_valid && in_sync, 4) |-> dbg_valid && (dbg_count == CNT_W'(1)));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_ns)
    dbg_valid |-> (dbg_count != '0));

  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_ns)
    mm_rd_en |=> mm_rvalid);

  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_ns)
    !mm_rd_en |=> !mm_rvalid);
endmodule

// File: tb/test_hist_accum.sv
module test_hist_accum;
  localparam int DATA_W = 5;
  localparam int BIN_W  = 3;
  localparam int NB     = 8;
  localparam int MAXS   = 200;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid, in_sync, mm_rd_en;
  logic [DATA_W-1:0] in_data;
  logic [BIN_W-1:0]  mm_addr;
  logic              mm_rvalid, dbg_valid;
  logic [CNT_W-1:0]  mm_rdata, dbg_count;
  logic [BIN_W-1:0]  dbg_bin;

  always #5 clk = ~clk;

  hist_accum #(.DATA_W(DATA_W), .BIN_W(BIN_W), .MAX_SAMPLES(MAXS)) i_hist_accum (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_data(in_data), .mm_rd_en(mm_rd_en), .mm_addr(mm_addr),
    .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata), .dbg_valid(dbg_valid),
    .dbg_bin(dbg_bin), .dbg_count(dbg_count));

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    wd = 0;
  int    ref_cnt [NB];
  bit    ev [8];
  int    eb [8];
  int    ec [8];
  bit    chk_on = 1'b0;
  string tag = "R11";

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  // arithmetic reference histogram, updated at the capture edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (in_valid === 1'b1) begin
      if (in_sync === 1'b1)
        for (int k = 0; k < NB; k++) ref_cnt[k] = 0;
      ref_cnt[in_data[DATA_W-1 -: BIN_W]] = ref_cnt[in_data[DATA_W-1 -: BIN_W]] + 1;
      ev[cyc % 8] = 1'b1;
      eb[cyc % 8] = int'(in_data[DATA_W-1 -: BIN_W]);
      ec[cyc % 8] = ref_cnt[in_data[DATA_W-1 -: BIN_W]];
    end else begin
      ev[cyc % 8] = 1'b0;
      eb[cyc % 8] = 0;
      ec[cyc % 8] = 0;
    end
  end

  // debug port: update for the sample captured at edge k shows after edge k+3
  always @(negedge clk) begin
    if (chk_on) begin
      int i;
      int act, exp;
      i   = (cyc - 3) % 8;
      act = ev[i] ? {dbg_valid, 4'(dbg_bin), dbg_count} : {dbg_valid, 12'h000};
      exp = ev[i] ? {1'b1, 4'(eb[i]), 8'(ec[i])} : 0;
      check(act == exp, tag, act, exp);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic push(input bit v, input bit s, input int b, input int lo);
    @(negedge clk);
    in_valid = v;
    in_sync  = s;
    in_data  = {b[BIN_W-1:0], lo[DATA_W-BIN_W-1:0]};
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) push(1'b0, 1'b0, k, k);
  endtask

  task automatic mm_read(input int a, input string t);
    @(negedge clk);
    mm_rd_en = 1'b1;
    mm_addr  = a[BIN_W-1:0];
    @(negedge clk);
    mm_rd_en = 1'b0;
    check(mm_rvalid === 1'b1 && int'(mm_rdata) == ref_cnt[a], t, int'(mm_rdata), ref_cnt[a]);
    @(negedge clk);
    check(mm_rvalid === 1'b0, t, int'(mm_rvalid), 0);
  endtask

  task automatic read_all(input string t);
    for (int a = 0; a < NB; a++) mm_read(a, t);
  endtask

  initial begin
    in_valid = 1'b0; in_sync = 1'b0; in_data = '0;
    mm_rd_en = 1'b0; mm_addr = '0;
    for (int k = 0; k < NB; k++) ref_cnt[k] = 0;
    for (int k = 0; k < 8; k++) begin ev[k] = 1'b0; eb[k] = 0; ec[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: reset state
    check(dbg_valid === 1'b0, "R11", int'(dbg_valid), 0);
    check(mm_rvalid === 1'b0, "R11", int'(mm_rvalid), 0);
    chk_on = 1'b1;
    read_all("R11");

    // R3: ascending data with periodic gaps
    tag = "R3";
    for (int i = 0; i < 32; i++) begin
      push(1'b1, 1'b0, i >> 2, i);
      if (i % 5 == 4) push(1'b0, 1'b0, i, i);
    end
    idle(6);
    read_all("R3");

    // R1: low data bits do not change the bin
    tag = "R1";
    for (int lo = 0; lo < 4; lo++) push(1'b1, 1'b0, 5, lo);
    push(1'b1, 1'b0, 2, 3);
    idle(6);
    mm_read(5, "R1");
    mm_read(2, "R1");

    // R2: invalid cycles leave counts untouched
    tag = "R2";
    for (int i = 0; i < 12; i++) push(i % 3 == 0, 1'b0, 6, i);
    idle(6);
    read_all("R2");

    // R4: consecutive hits on one bin
    tag = "R4";
    for (int i = 0; i < 6; i++) push(1'b1, 1'b0, 3, i);
    idle(6);
    mm_read(3, "R4");

    // R5: alternating bins
    tag = "R5";
    for (int i = 0; i < 8; i++) push(1'b1, 1'b0, i % 2, i);
    idle(6);
    mm_read(0, "R5");
    mm_read(1, "R5");

    // R6: repeat at distance three
    tag = "R6";
    push(1'b1, 1'b0, 0, 0); push(1'b1, 1'b0, 1, 1);
    push(1'b1, 1'b0, 1, 2); push(1'b1, 1'b0, 0, 3);
    push(1'b1, 1'b0, 2, 0); push(1'b1, 1'b0, 6, 0);
    push(1'b1, 1'b0, 7, 0); push(1'b1, 1'b0, 2, 1);
    idle(6);
    read_all("R6");

    // R7: restart with the same bin in flight, then back-to-back markers
    tag = "R7";
    push(1'b1, 1'b0, 5, 0); push(1'b1, 1'b0, 5, 1);
    push(1'b1, 1'b1, 5, 2); push(1'b1, 1'b0, 5, 3);
    push(1'b1, 1'b0, 4, 0);
    push(1'b1, 1'b1, 4, 1); push(1'b1, 1'b1, 4, 2); push(1'b1, 1'b1, 1, 3);
    push(1'b1, 1'b0, 4, 0); push(1'b1, 1'b0, 1, 0);
    idle(6);
    read_all("R7");

    // R9: sweep of repeat distances and gaps with concurrent port reads
    tag = "R9";
    for (int gap = 0; gap < 3; gap++) begin
      push(1'b1, 1'b1, gap, 0);
      for (int d = 1; d <= 4; d++) begin
        for (int a = 0; a < NB; a++) begin
          int b;
          b = (a + 3) % NB;
          mm_rd_en = a[0];
          mm_addr  = BIN_W'(a + d);
          push(1'b1, 1'b0, a, d);
          for (int k = 1; k < d; k++) begin
            if (gap != 0 && k == gap) push(1'b0, 1'b0, a, k);
            push(1'b1, 1'b0, b, k);
          end
          push(1'b1, 1'b0, a, 3);
        end
      end
    end
    @(negedge clk);
    mm_rd_en = 1'b0;
    idle(6);
    read_all("R9");

    // R10: one bin to the interval maximum
    tag = "R10";
    push(1'b1, 1'b1, 7, 0);
    for (int i = 1; i < MAXS; i++) push(1'b1, 1'b0, 7, i);
    idle(6);
    mm_read(7, "R10");

    // R8: port readout of the finished interval, untouched bins read zero
    tag = "R8";
    read_all("R8");
    idle(4);

    chk_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule